// File: doc/BRIEF.md
# Interruptible GPIO Port Controller

This block controls one general-purpose pin port. Its width is set by a parameter and defaults to eight pins. A small synchronous register bus configures each pin. Every pin can be a plain software-driven I/O, or it can be handed to one of two peripheral functions. A plain input can also ask the pad for a pull-up or pull-down resistor. The block does not model the pad itself. It produces the output value, the output enable and the pull requests that a pad cell would take.

Pin inputs pass through a two-flop synchronizer. The synchronized level is what software reads, and it is also what feeds the edge detector. Each pin keeps a sticky pending flag. That flag is set by the pin's chosen edge or by a software write, and only software clears it. The enabled flags are ORed into one interrupt request for an external interrupt controller.

Register offsets on the bus:
- 0: pin level (read-only)
- 1: drive value
- 2: direction
- 3: resistor enable
- 4: function-select low bit
- 5: function-select high bit
- 6: interrupt enable
- 7: edge polarity
- 8: pending flags

Top module: `gpio_port`

## Requirements
- R1: After reset, every writable register reads 0. Every pin is a plain input with its output enable low and no pull requested, and `irq` is low.
- R2: Per pin, the function code is {bit of offset 5, bit of offset 4}.
  - 00 selects plain I/O.
  - 01 passes `prim_out`/`prim_oe` to the pin.
  - 11 passes `sec_out`/`sec_oe` to the pin.
  - 10 is reserved: the pin drives 0 with its output enable low.
- R3: In plain I/O mode, a direction bit of 1 raises `pin_oe` and 0 lowers it. `pin_out` follows the drive register bit.
- R4: Offset 0 returns the pin levels after two synchronizer flops. Bus writes to offset 0 change no register.
- R5: A plain I/O input pin with its resistor-enable bit set requests a pull-up when its drive bit is 1 and a pull-down when it is 0. With the resistor disabled, or in any peripheral or reserved mode, it requests no pull.
- R6: A plain I/O pin that is both an output and resistor-enabled requests no pull and raises its `pull_err` bit.
- R7: When a pin's polarity bit is 0, a rising synchronized edge sets its pending flag. When the bit is 1, a falling edge does. The flag becomes visible on the third rising clock edge after the pin changes, and it stays set until software changes it.
- R8: A write to offset 8 loads the pending flags directly, so software can set or clear them. If a hardware edge and a software clear hit the same flag in the same cycle, the flag ends up set.
- R9: A pin whose function code is not 00 never gets its pending flag set by its own edges.
- R10: `irq` is high exactly when some pending flag has its interrupt-enable bit (offset 6) set. Each enable bit masks only its own pin.
- R11: `prim_in` carries the synchronized level on pins with code 01 and 0 elsewhere. `sec_in` carries it on pins with code 11 and 0 elsewhere.
- R12: Read data is registered. It appears the clock edge after the read strobe and holds until the next read. An unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | WIDTH | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Asynchronous pin levels |
| pin_out | output | WIDTH | Value to drive on each pin |
| pin_oe | output | WIDTH | Output enable per pin |
| pull_up | output | WIDTH | Pull-up request per pin |
| pull_dn | output | WIDTH | Pull-down request per pin |
| pull_err | output | WIDTH | Illegal output-with-resistor flag per pin |
| prim_out | input | WIDTH | Primary peripheral output value |
| prim_oe | input | WIDTH | Primary peripheral output enable |
| prim_in | output | WIDTH | Synchronized level to primary peripheral |
| sec_out | input | WIDTH | Secondary peripheral output value |
| sec_oe | input | WIDTH | Secondary peripheral output enable |
| sec_in | output | WIDTH | Synchronized level to secondary peripheral |
| irq | output | 1 | Combined interrupt request |

## Verification
A corrupted configuration bit shows up at the pin outputs in the same cycle it is written, because the pin mux is combinational from the registers. A wrong pending flag shows on `irq`, or on a pending read, one cycle after the edge is detected. That is three clock edges after the pin changes. Lost stickiness only appears later, when the pin returns to its idle level and a read still expects the flag. The bench therefore reads back the flags after the stimulus has gone away. The collision case needs the software clear to land exactly on the detection cycle, so the bench places it there by counting edges.

// File: rtl/gpio_pkg.sv
// gpio_pkg: shared constants and types of the GPIO port controller.
// Assumes a 4-bit register offset on the bus; the offsets below are fixed.
package gpio_pkg;
    localparam int ADDR_W = 4;

    // Per-pin function code, {high bit, low bit}.
    typedef enum logic [1:0] {
        FN_GPIO = 2'b00,
        FN_PRIM = 2'b01,
        FN_RSVD = 2'b10,
        FN_SEC  = 2'b11
    } fn_t;

    localparam logic [ADDR_W-1:0] A_LEVEL = 4'h0;
    localparam logic [ADDR_W-1:0] A_DRIVE = 4'h1;
    localparam logic [ADDR_W-1:0] A_DIR   = 4'h2;
    localparam logic [ADDR_W-1:0] A_PULL  = 4'h3;
    localparam logic [ADDR_W-1:0] A_FNLO  = 4'h4;
    localparam logic [ADDR_W-1:0] A_FNHI  = 4'h5;
    localparam logic [ADDR_W-1:0] A_IEN   = 4'h6;
    localparam logic [ADDR_W-1:0] A_POL   = 4'h7;
    localparam logic [ADDR_W-1:0] A_PEND  = 4'h8;
endpackage

// File: rtl/gpio_insync.sv
// gpio_insync: per-pin synchronizer chain plus edge detector.
// Assumes STAGES >= 2. level is the last synchronizer flop; rise/fall are
// single-cycle pulses comparing level with its value one cycle earlier.
module gpio_insync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] prev_q;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_pin
            logic [STAGES-1:0] chain_q;

            // Shift the raw pin level through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], pin_in[i]};
            end

            assign level[i] = chain_q[LAST];
        end
    endgenerate

    // Remember last cycle's synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;
endmodule

// File: rtl/gpio_pinmux.sv
// gpio_pinmux: per-pin routing between register bank, peripherals and pad.
// Purely combinational. Reserved code drives nothing. Pulls are only
// requested for plain I/O inputs; output plus resistor is flagged as error.
module gpio_pinmux
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] fn_lo,
    input  logic [WIDTH-1:0] fn_hi,
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] drive,
    input  logic [WIDTH-1:0] pull_en,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] prim_out,
    input  logic [WIDTH-1:0] prim_oe,
    input  logic [WIDTH-1:0] sec_out,
    input  logic [WIDTH-1:0] sec_oe,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pull_up,
    output logic [WIDTH-1:0] pull_dn,
    output logic [WIDTH-1:0] pull_err,
    output logic [WIDTH-1:0] prim_in,
    output logic [WIDTH-1:0] sec_in,
    output logic [WIDTH-1:0] gpio_mask
);
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_pin
            fn_t  fn;
            logic o, oe, up, dn, err, to_prim, to_sec, is_gpio;

            assign fn = fn_t'({fn_hi[i], fn_lo[i]});

            // Select drive source and pull request from the function code.
            always_comb begin
                o       = 1'b0;
                oe      = 1'b0;
                up      = 1'b0;
                dn      = 1'b0;
                err     = 1'b0;
                to_prim = 1'b0;
                to_sec  = 1'b0;
                is_gpio = 1'b0;
                unique case (fn)
                    FN_GPIO: begin
                        is_gpio = 1'b1;
                        o       = drive[i];
                        oe      = dir[i];
                        err     = dir[i] & pull_en[i];
                        up      = ~dir[i] & pull_en[i] & drive[i];
                        dn      = ~dir[i] & pull_en[i] & ~drive[i];
                    end
                    FN_PRIM: begin
                        o       = prim_out[i];
                        oe      = prim_oe[i];
                        to_prim = 1'b1;
                    end
                    FN_SEC: begin
                        o       = sec_out[i];
                        oe      = sec_oe[i];
                        to_sec  = 1'b1;
                    end
                    FN_RSVD: begin
                        o       = 1'b0;
                        oe      = 1'b0;
                    end
                    default: begin
                        o       = 1'b0;
                        oe      = 1'b0;
                    end
                endcase
            end

            assign pin_out[i]   = o;
            assign pin_oe[i]    = oe;
            assign pull_up[i]   = up;
            assign pull_dn[i]   = dn;
            assign pull_err[i]  = err;
            assign prim_in[i]   = to_prim & level[i];
            assign sec_in[i]    = to_sec & level[i];
            assign gpio_mask[i] = is_gpio;
        end
    endgenerate
endmodule

// File: rtl/gpio_regs.sv
// gpio_regs: register bank, sticky pending flags and registered read port.
// Assumes single-cycle write and read strobes. Edges count only on pins
// in plain I/O mode (gpio_mask); a hardware set wins over a software clear.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  level,
    input  logic [WIDTH-1:0]  rise,
    input  logic [WIDTH-1:0]  fall,
    input  logic [WIDTH-1:0]  gpio_mask,
    output logic [WIDTH-1:0]  drive,
    output logic [WIDTH-1:0]  dir,
    output logic [WIDTH-1:0]  pull_en,
    output logic [WIDTH-1:0]  fn_lo,
    output logic [WIDTH-1:0]  fn_hi,
    output logic [WIDTH-1:0]  irq_en,
    output logic [WIDTH-1:0]  pend
);
    logic [WIDTH-1:0] pol_q;
    logic [WIDTH-1:0] hit;
    logic [WIDTH-1:0] rd_mux;
    logic [WIDTH-1:0] rdata_q;
    logic             pend_wr;

    assign hit     = gpio_mask & ((pol_q & fall) | (~pol_q & rise));
    assign pend_wr = bus_we && (bus_addr == A_PEND);

    // Configuration registers: load on a write strobe to their offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive   <= '0;
            dir     <= '0;
            pull_en <= '0;
            fn_lo   <= '0;
            fn_hi   <= '0;
            irq_en  <= '0;
            pol_q   <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                A_DRIVE: drive   <= bus_wdata;
                A_DIR:   dir     <= bus_wdata;
                A_PULL:  pull_en <= bus_wdata;
                A_FNLO:  fn_lo   <= bus_wdata;
                A_FNHI:  fn_hi   <= bus_wdata;
                A_IEN:   irq_en  <= bus_wdata;
                A_POL:   pol_q   <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Pending flags: software loads them, detected edges OR in on top.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend <= '0;
        else if (pend_wr) pend <= bus_wdata | hit;
        else              pend <= pend | hit;
    end

    // Read multiplexer over all mapped offsets.
    always_comb begin
        case (bus_addr)
            A_LEVEL: rd_mux = level;
            A_DRIVE: rd_mux = drive;
            A_DIR:   rd_mux = dir;
            A_PULL:  rd_mux = pull_en;
            A_FNLO:  rd_mux = fn_lo;
            A_FNHI:  rd_mux = fn_hi;
            A_IEN:   rd_mux = irq_en;
            A_POL:   rd_mux = pol_q;
            A_PEND:  rd_mux = pend;
            default: rd_mux = '0;
        endcase
    end

    // Capture read data on the read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_re) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/gpio_port.sv
// gpio_port: top of the interruptible GPIO port controller.
// Ties synchronizer, register bank and pin mux together and forms the
// combined interrupt. Assumes pins are idle-low while reset is applied.
module gpio_port
    import gpio_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic [WIDTH-1:0]  pull_up,
    output logic [WIDTH-1:0]  pull_dn,
    output logic [WIDTH-1:0]  pull_err,
    input  logic [WIDTH-1:0]  prim_out,
    input  logic [WIDTH-1:0]  prim_oe,
    output logic [WIDTH-1:0]  prim_in,
    input  logic [WIDTH-1:0]  sec_out,
    input  logic [WIDTH-1:0]  sec_oe,
    output logic [WIDTH-1:0]  sec_in,
    output logic              irq
);
    logic [WIDTH-1:0] level, rise, fall, gpio_mask;
    logic [WIDTH-1:0] drive, dir, pull_en, fn_lo, fn_hi, irq_en, pend;

    gpio_insync #(.WIDTH(WIDTH), .STAGES(STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .level  (level),
        .rise   (rise),
        .fall   (fall)
    );

    gpio_regs #(.WIDTH(WIDTH)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .level     (level),
        .rise      (rise),
        .fall      (fall),
        .gpio_mask (gpio_mask),
        .drive     (drive),
        .dir       (dir),
        .pull_en   (pull_en),
        .fn_lo     (fn_lo),
        .fn_hi     (fn_hi),
        .irq_en    (irq_en),
        .pend      (pend)
    );

    gpio_pinmux #(.WIDTH(WIDTH)) mux_i (
        .fn_lo     (fn_lo),
        .fn_hi     (fn_hi),
        .dir       (dir),
        .drive     (drive),
        .pull_en   (pull_en),
        .level     (level),
        .prim_out  (prim_out),
        .prim_oe   (prim_oe),
        .sec_out   (sec_out),
        .sec_oe    (sec_oe),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .pull_up   (pull_up),
        .pull_dn   (pull_dn),
        .pull_err  (pull_err),
        .prim_in   (prim_in),
        .sec_in    (sec_in),
        .gpio_mask (gpio_mask)
    );

    // Combined request: any pending flag whose enable is set.
    assign irq = |(pend & irq_en);
endmodule

// File: rtl/gpio_port_chk.sv
// gpio_port_chk: property checker for gpio_port, attached by bind below.
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_re,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic [WIDTH-1:0]  level,
    input logic [WIDTH-1:0]  pend,
    input logic [WIDTH-1:0]  irq_en,
    input logic              irq,
    input logic [WIDTH-1:0]  pin_oe,
    input logic [WIDTH-1:0]  pull_up,
    input logic [WIDTH-1:0]  pull_dn,
    input logic [WIDTH-1:0]  pull_err,
    input logic [WIDTH-1:0]  fn_lo,
    input logic [WIDTH-1:0]  fn_hi
);
    a_r2_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & fn_hi & ~fn_lo) == '0);

    a_r5_pull_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_up & pull_dn) == '0);

    a_r6_no_pull_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_err & (pull_up | pull_dn)) == '0);

    a_r4_level_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == A_LEVEL) |=> (bus_rdata == $past(level)));

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == A_PEND) |=> ((pend & $past(pend)) == $past(pend)));

    a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq);

    a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend != '0));

    a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr > A_PEND) |=> (bus_rdata == '0));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .level     (level),
    .pend      (pend),
    .irq_en    (irq_en),
    .irq       (irq),
    .pin_oe    (pin_oe),
    .pull_up   (pull_up),
    .pull_dn   (pull_dn),
    .pull_err  (pull_err),
    .fn_lo     (fn_lo),
    .fn_hi     (fn_hi)
);

// File: tb/gpio_port_tb_top.sv
`timescale 1ns/1ps
module gpio_port_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic         bus_we = 1'b0;
    logic         bus_re = 1'b0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pin_out, pin_oe, pull_up, pull_dn, pull_err;
    logic [W-1:0] prim_out = 8'hA5;
    logic [W-1:0] prim_oe  = 8'h0F;
    logic [W-1:0] sec_out  = 8'h3C;
    logic [W-1:0] sec_oe   = 8'hF0;
    logic [W-1:0] prim_in, sec_in;
    logic         irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pull_up(pull_up), .pull_dn(pull_dn), .pull_err(pull_err),
        .prim_out(prim_out), .prim_oe(prim_oe), .prim_in(prim_in),
        .sec_out(sec_out), .sec_oe(sec_oe), .sec_in(sec_in), .irq(irq)
    );

    // {fn_lo, fn_hi, dir, drive, pull_en, exp_out, exp_oe, exp_up, exp_dn, exp_err}
    localparam logic [79:0] VEC [8] = '{
        80'h00_00_FF_5A_00_5A_FF_00_00_00,
        80'h00_00_00_F0_FF_F0_00_F0_0F_00,
        80'h00_00_0F_33_FF_33_0F_30_C0_0F,
        80'hFF_00_FF_00_FF_A5_0F_00_00_00,
        80'hFF_FF_FF_00_FF_3C_F0_00_00_00,
        80'h00_FF_FF_00_FF_00_00_00_00_00,
        80'h0F_F3_00_FF_FF_04_0C_00_00_00,
        80'hF0_00_03_0A_0F_AA_03_08_04_03
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [W-1:0] d);
        bus_addr = a; bus_re = 1'b1;
        @(posedge clk); #1;
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;

        // R1: reset state
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(1);
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 pulls", {pull_up, pull_dn}, 0);
        chk("R1 irq", irq, 0);
        rd(4'h2, v); chk("R1 dir", v, 0);
        rd(4'h4, v); chk("R1 fn_lo", v, 0);
        rd(4'h5, v); chk("R1 fn_hi", v, 0);
        rd(4'h8, v); chk("R1 pend", v, 0);

        // R2 R3 R5 R6: pin mux vectors
        for (int k = 0; k < 8; k++) begin
            wr(4'h4, VEC[k][79:72]);
            wr(4'h5, VEC[k][71:64]);
            wr(4'h2, VEC[k][63:56]);
            wr(4'h1, VEC[k][55:48]);
            wr(4'h3, VEC[k][47:40]);
            chk("R2/R3 pin_out", pin_out, VEC[k][39:32]);
            chk("R2/R3 pin_oe", pin_oe, VEC[k][31:24]);
            chk("R5 pull_up", pull_up, VEC[k][23:16]);
            chk("R5 pull_dn", pull_dn, VEC[k][15:8]);
            chk("R6 pull_err", pull_err, VEC[k][7:0]);
        end
        for (int a = 1; a < 6; a++) wr(4'(a), 8'h00);

        // R4 R11 R9: synchronized level, routing, read-only input register
        wr(4'h4, 8'h0F);
        wr(4'h5, 8'h03);
        pin_in = 8'h96;
        wait_cyc(3);
        rd(4'h0, v); chk("R4 level read", v, 8'h96);
        chk("R11 prim_in", prim_in, 8'h04);
        chk("R11 sec_in", sec_in, 8'h02);
        wr(4'h0, 8'hFF);
        rd(4'h0, v); chk("R4 write ignored level", v, 8'h96);
        rd(4'h1, v); chk("R4 write ignored drive", v, 8'h00);
        rd(4'h8, v); chk("R9 routed pins no flag", v, 8'h90);
        pin_in = 8'h00;
        wait_cyc(4);
        wr(4'h4, 8'h00);
        wr(4'h5, 8'h00);
        wr(4'h8, 8'h00);

        // R7: rising-edge latency and stickiness
        wr(4'h7, 8'h00);
        wr(4'h6, 8'h01);
        pin_in = 8'h01;
        wait_cyc(1); chk("R7 latency edge1", irq, 0);
        wait_cyc(1); chk("R7 latency edge2", irq, 0);
        wait_cyc(1); chk("R7 latency edge3", irq, 1);
        pin_in = 8'h00;
        wait_cyc(4);
        rd(4'h8, v); chk("R7 sticky", v, 8'h01);

        // R10: per-pin masking
        wr(4'h6, 8'hFE); chk("R10 masked", irq, 0);
        wr(4'h6, 8'h01); chk("R10 unmasked", irq, 1);
        wr(4'h8, 8'h00); chk("R8 sw clear irq", irq, 0);

        // R7: falling polarity
        wr(4'h7, 8'h02);
        wr(4'h6, 8'h02);
        pin_in = 8'h02;
        wait_cyc(4);
        rd(4'h8, v); chk("R7 rise ignored when falling selected", v, 8'h00);
        pin_in = 8'h00;
        wait_cyc(4);
        rd(4'h8, v); chk("R7 falling edge sets", v, 8'h02);

        // R8: software set, then set beats clear in same cycle
        wr(4'h8, 8'h80);
        wr(4'h6, 8'h80); chk("R8 sw set irq", irq, 1);
        rd(4'h8, v); chk("R8 sw set value", v, 8'h80);
        wr(4'h7, 8'h00);
        pin_in = 8'h04;
        @(posedge clk);
        @(posedge clk); #1;
        bus_addr = 4'h8; bus_wdata = 8'h00; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
        rd(4'h8, v); chk("R8 set wins over clear", v, 8'h04);

        // R9: reserved and primary pins ignore their edges
        wr(4'h5, 8'h08);
        pin_in = 8'h0C;
        wait_cyc(4);
        rd(4'h8, v); chk("R9 reserved pin no flag", v, 8'h04);
        wr(4'h5, 8'h00);
        wr(4'h4, 8'h10);
        pin_in = 8'h1C;
        wait_cyc(4);
        rd(4'h8, v); chk("R9 primary pin no flag", v, 8'h04);

        // R12: unmapped offset and hold
        rd(4'hF, v); chk("R12 unmapped zero", v, 8'h00);
        wait_cyc(2);
        chk("R12 rdata held", bus_rdata, 8'h00);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule